// File: doc/BRIEF.md
# Guarded Dual-Accumulator Multiply-Accumulate Unit

This block multiplies two 17-bit operands in a single cycle and adds the product into one of two 40-bit accumulators, called A and B. Each accumulator is split into an 8-bit guard field (bits 39..32), a high word (bits 31..16) and a low word (bits 15..0). The guard field lets long accumulation runs grow past the 32-bit signed range without wrapping. The block has no internal pipeline: an operation presented in one cycle shows up in the destination accumulator right after the next rising clock edge.

Each multiplier operand has its own source select. A source is one of:
- an external temporary-register value;
- a data-bus word;
- a program-bus word;
- bits 32..16 of either accumulator, fed back directly.

Each 16-bit source is widened to 17 bits by sign or zero extension, set per operand.

A fractional control doubles the product. A saturation control clamps results to the 32-bit signed range and raises a sticky per-accumulator overflow flag.

Top module: `mac_dual_acc`

## Requirements
- R1: An active-low asynchronous reset clears both accumulators and both overflow flags to zero.
- R2: With en=1 and op=00 (multiply only), the destination accumulator receives the 40-bit sign-extended product in the next cycle. The destination is set by dst: 0 selects A and 1 selects B.
- R3: op=01 adds the product to the destination and op=10 subtracts the product from it. With saturation off, the result wraps modulo 2^40, so sums beyond 32 bits spill into the guard bits.
- R4: When en=0 or op=11, neither accumulator changes.
- R5: An operation never changes the accumulator that is not its destination.
- R6: Operand select codes, the same for x_sel and y_sel:
  - 0 selects t_val;
  - 1 selects dbus;
  - 2 selects pbus;
  - 3 selects bits 32..16 of accumulator A (fb_sel=0) or B (fb_sel=1), taken as a 17-bit signed value.
- R7: For select codes 0 to 2, the operand's signed control gives sign extension to 17 bits when it is 1 and zero extension when it is 0.
- R8: With frac=1, the product is shifted left by one bit before it is written or accumulated.
- R9: With sat_en=1, an exact result above 2^31-1 is written as 0x007FFFFFFF and a result below -2^31 is written as 0xFF80000000.
- R10: A clamp raises the destination's overflow flag. The flag stays set until its clear input is pulsed. A clear acts even in cycles with no operation. A new clamp in the same cycle as a clear leaves the flag set.
- R11: With sat_en=0, no overflow flag is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Operation valid |
| op | input | 2 | 00 multiply, 01 accumulate-add, 10 accumulate-subtract, 11 none |
| dst | input | 1 | Destination: 0 = A, 1 = B |
| x_sel | input | 2 | First operand source |
| x_signed | input | 1 | First operand sign extension |
| y_sel | input | 2 | Second operand source |
| y_signed | input | 1 | Second operand sign extension |
| fb_sel | input | 1 | Accumulator used by select code 3 |
| frac | input | 1 | Double the product |
| sat_en | input | 1 | Saturation enable |
| t_val | input | 16 | Temporary-register multiplicand |
| dbus | input | 16 | Data-bus operand |
| pbus | input | 16 | Program-bus operand |
| clr_ovf_a | input | 1 | Clear the overflow flag of A |
| clr_ovf_b | input | 1 | Clear the overflow flag of B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | Sticky overflow flag of A |
| ovf_b | output | 1 | Sticky overflow flag of B |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:
- **Unsigned 0xFFFF times 0xFFFF.** A design that sign-extends the operands would produce +1 instead of 0xFFFE0001.
- **Repeated unsigned accumulation past 2^32.** A design without guard bits, or one that wraps at 32 bits, would lose the carry into bits 39..32.
- **Fractional negative products at the lower clamp edge.** A saturation test done on the truncated 40-bit value, rather than on the exact sum, would clamp to the wrong bound or not at all.
- **Accumulator feedback operands.** Selecting the wrong bit slice would give products off by powers of two.
- **Overflow-flag clear cycles.** A design where the clear wins over a coincident clamp would drop the sticky flag.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_MPY = 2'b00,
        OP_MAC = 2'b01,
        OP_MSU = 2'b10,
        OP_NOP = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        SRC_TREG = 2'b00,
        SRC_DBUS = 2'b01,
        SRC_PBUS = 2'b10,
        SRC_ACCH = 2'b11
    } mac_src_e;
endpackage

// File: rtl/mac_opsel.sv
module mac_opsel #(
    parameter int DW = 16
) (
    input  logic [1:0]        sel,
    input  logic              sgn,
    input  logic [DW-1:0]     t_val,
    input  logic [DW-1:0]     dbus,
    input  logic [DW-1:0]     pbus,
    input  logic [DW:0]       fb,
    output logic signed [DW:0] opnd
);
    logic [DW-1:0] word;

    always_comb begin
        unique case (sel)
            mac_pkg::SRC_TREG: word = t_val;
            mac_pkg::SRC_DBUS: word = dbus;
            default:           word = pbus;
        endcase
        if (sel == mac_pkg::SRC_ACCH) begin
            opnd = $signed(fb);
        end else begin
            opnd = $signed({sgn & word[DW-1], word});
        end
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic signed [DW:0] x,
    input  logic signed [DW:0] y,
    input  logic               frac,
    output logic [AW-1:0]      prod
);
    localparam int PW = 2 * DW + 2;

    logic signed [PW-1:0] raw;
    logic [AW-1:0]        wide;

    always_comb begin
        raw  = x * y;
        wide = {{(AW-PW){raw[PW-1]}}, raw};
        prod = frac ? {wide[AW-2:0], 1'b0} : wide;
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW:0]   sum,
    input  logic          sat_en,
    output logic [AW-1:0] res,
    output logic          ovf
);
    localparam logic [AW:0] MAXV = {{(AW-2*DW+2){1'b0}}, {(2*DW-1){1'b1}}};
    localparam logic [AW:0] MINV = ~MAXV;

    logic above, below;

    always_comb begin
        above = $signed(sum) > $signed(MAXV);
        below = $signed(sum) < $signed(MINV);
        ovf   = sat_en & (above | below);
        if (sat_en && above) begin
            res = MAXV[AW-1:0];
        end else if (sat_en && below) begin
            res = MINV[AW-1:0];
        end else begin
            res = sum[AW-1:0];
        end
    end
endmodule

// File: rtl/mac_dual_acc.sv
module mac_dual_acc #(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        op,
    input  logic              dst,
    input  logic [1:0]        x_sel,
    input  logic              x_signed,
    input  logic [1:0]        y_sel,
    input  logic              y_signed,
    input  logic              fb_sel,
    input  logic              frac,
    input  logic              sat_en,
    input  logic [DW-1:0]     t_val,
    input  logic [DW-1:0]     dbus,
    input  logic [DW-1:0]     pbus,
    input  logic              clr_ovf_a,
    input  logic              clr_ovf_b,
    output logic [2*DW+GW-1:0] acc_a,
    output logic [2*DW+GW-1:0] acc_b,
    output logic              ovf_a,
    output logic              ovf_b
);
    localparam int AW = 2 * DW + GW;

    typedef struct packed {
        logic [AW-1:0] acc_a;
        logic [AW-1:0] acc_b;
        logic          ovf_a;
        logic          ovf_b;
    } state_t;

    state_t st_d, st_q;

    logic [DW:0]        fb;
    logic [1:0]         sel_v [2];
    logic               sgn_v [2];
    logic signed [DW:0] opnd_v [2];
    logic [AW-1:0]      prod;
    logic [AW-1:0]      cur;
    logic [AW:0]        sum;
    logic [AW-1:0]      res;
    logic               clamp;
    logic               active;

    assign fb       = fb_sel ? st_q.acc_b[2*DW:DW] : st_q.acc_a[2*DW:DW];
    assign sel_v[0] = x_sel;
    assign sel_v[1] = y_sel;
    assign sgn_v[0] = x_signed;
    assign sgn_v[1] = y_signed;

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        mac_opsel #(.DW(DW)) u_sel (
            .sel   (sel_v[i]),
            .sgn   (sgn_v[i]),
            .t_val (t_val),
            .dbus  (dbus),
            .pbus  (pbus),
            .fb    (fb),
            .opnd  (opnd_v[i])
        );
    end

    mac_mult #(.DW(DW), .AW(AW)) u_mult (
        .x    (opnd_v[0]),
        .y    (opnd_v[1]),
        .frac (frac),
        .prod (prod)
    );

    always_comb begin
        cur = dst ? st_q.acc_b : st_q.acc_a;
        unique case (op)
            mac_pkg::OP_MAC: sum = {cur[AW-1], cur} + {prod[AW-1], prod};
            mac_pkg::OP_MSU: sum = {cur[AW-1], cur} - {prod[AW-1], prod};
            default:         sum = {prod[AW-1], prod};
        endcase
    end

    mac_sat #(.DW(DW), .AW(AW)) u_sat (
        .sum    (sum),
        .sat_en (sat_en),
        .res    (res),
        .ovf    (clamp)
    );

    assign active = en && (op != mac_pkg::OP_NOP);

    always_comb begin
        st_d = st_q;
        if (clr_ovf_a) st_d.ovf_a = 1'b0;
        if (clr_ovf_b) st_d.ovf_b = 1'b0;
        if (active) begin
            if (dst) begin
                st_d.acc_b = res;
                if (clamp) st_d.ovf_b = 1'b1;
            end else begin
                st_d.acc_a = res;
                if (clamp) st_d.ovf_a = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_a = st_q.acc_a;
    assign acc_b = st_q.acc_b;
    assign ovf_a = st_q.ovf_a;
    assign ovf_b = st_q.ovf_b;
endmodule

// File: rtl/mac_dual_acc_chk.sv
module mac_dual_acc_chk #(
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [1:0]    op,
    input logic          dst,
    input logic          sat_en,
    input logic          clr_ovf_a,
    input logic          clr_ovf_b,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b,
    input logic          ovf_a,
    input logic          ovf_b
);
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || op == 2'b11) |=> ($stable(acc_a) && $stable(acc_b)));

    p_keep_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != 2'b11 && !dst) |=> $stable(acc_b));

    p_keep_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != 2'b11 && dst) |=> $stable(acc_a));

    p_range_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != 2'b11 && sat_en && !dst) |=>
        (acc_a[AW-1:31] == '0 || acc_a[AW-1:31] == '1));

    p_range_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != 2'b11 && sat_en && dst) |=>
        (acc_b[AW-1:31] == '0 || acc_b[AW-1:31] == '1));

    p_sticky_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_a && !clr_ovf_a) |=> ovf_a);

    p_sticky_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_b && !clr_ovf_b) |=> ovf_b);

    p_no_flag_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_a && !(en && op != 2'b11 && sat_en && !dst)) |=> !ovf_a);

    p_no_flag_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_b && !(en && op != 2'b11 && sat_en && dst)) |=> !ovf_b);
endmodule

bind mac_dual_acc mac_dual_acc_chk #(.AW(2*DW+GW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .op        (op),
    .dst       (dst),
    .sat_en    (sat_en),
    .clr_ovf_a (clr_ovf_a),
    .clr_ovf_b (clr_ovf_b),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .ovf_a     (ovf_a),
    .ovf_b     (ovf_b)
);

// File: tb/mac_dual_acc_tb.sv
module mac_dual_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  op = 2'b11;
    logic        dst = 1'b0;
    logic [1:0]  x_sel = 2'b00;
    logic        x_signed = 1'b1;
    logic [1:0]  y_sel = 2'b01;
    logic        y_signed = 1'b1;
    logic        fb_sel = 1'b0;
    logic        frac = 1'b0;
    logic        sat_en = 1'b0;
    logic [15:0] t_val = '0;
    logic [15:0] dbus = '0;
    logic [15:0] pbus = '0;
    logic        clr_ovf_a = 1'b0;
    logic        clr_ovf_b = 1'b0;
    logic [39:0] acc_a, acc_b;
    logic        ovf_a, ovf_b;

    int checks = 0;
    int fails = 0;
    logic [39:0] m_a = '0, m_b = '0;
    logic        m_oa = 1'b0, m_ob = 1'b0;

    always #4 clk = ~clk;

    mac_dual_acc u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .dst(dst),
        .x_sel(x_sel), .x_signed(x_signed), .y_sel(y_sel), .y_signed(y_signed),
        .fb_sel(fb_sel), .frac(frac), .sat_en(sat_en),
        .t_val(t_val), .dbus(dbus), .pbus(pbus),
        .clr_ovf_a(clr_ovf_a), .clr_ovf_b(clr_ovf_b),
        .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b)
    );

    function automatic longint s40(logic [39:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint pick(logic [1:0] sel, logic sg);
        logic [15:0] w;
        logic [39:0] f;
        if (sel == 2'd3) begin
            f = fb_sel ? m_b : m_a;
            return longint'($signed(f[32:16]));
        end
        w = (sel == 2'd0) ? t_val : (sel == 2'd1) ? dbus : pbus;
        return sg ? longint'($signed(w)) : longint'({48'd0, w});
    endfunction

    // Updates the model from the inputs currently applied (one clock edge)
    task automatic model_step();
        longint p, r;
        logic   cl;
        logic [63:0] rv;
        cl = 1'b0;
        if (clr_ovf_a) m_oa = 1'b0;
        if (clr_ovf_b) m_ob = 1'b0;
        if (en && op != 2'b11) begin
            p = pick(x_sel, x_signed) * pick(y_sel, y_signed);
            if (frac) p = p * 2;
            if (op == 2'b00)      r = p;
            else if (op == 2'b01) r = s40(dst ? m_b : m_a) + p;
            else                  r = s40(dst ? m_b : m_a) - p;
            if (sat_en && r > 64'sd2147483647) begin r = 64'sd2147483647; cl = 1'b1; end
            if (sat_en && r < -64'sd2147483648) begin r = -64'sd2147483648; cl = 1'b1; end
            rv = r;
            if (dst) begin m_b = rv[39:0]; if (cl) m_ob = 1'b1; end
            else     begin m_a = rv[39:0]; if (cl) m_oa = 1'b1; end
        end
    endtask

    task automatic check(string req);
        checks++;
        if (acc_a !== m_a || acc_b !== m_b || ovf_a !== m_oa || ovf_b !== m_ob) begin
            fails++;
            $display("FAIL %s: got a=%h b=%h oa=%b ob=%b expected a=%h b=%h oa=%b ob=%b",
                     req, acc_a, acc_b, ovf_a, ovf_b, m_a, m_b, m_oa, m_ob);
        end
    endtask

    // Apply inputs at a falling edge, clock once, check at the next falling edge
    task automatic step(string req);
        model_step();
        @(negedge clk);
        check(req);
    endtask

    task automatic setop(logic e, logic [1:0] o, logic d, logic [1:0] xs, logic xg,
                         logic [1:0] ys, logic yg, logic fr, logic sa,
                         logic [15:0] t, logic [15:0] db, logic [15:0] pb);
        en = e; op = o; dst = d; x_sel = xs; x_signed = xg; y_sel = ys; y_signed = yg;
        frac = fr; sat_en = sa; t_val = t; dbus = db; pbus = pb;
        clr_ovf_a = 1'b0; clr_ovf_b = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: multiply only, signed 0x4000 * 0x4000 into A
        setop(1, 2'b00, 0, 2'd0, 1, 2'd1, 1, 0, 0, 16'h4000, 16'h4000, 16'h0);
        step("R2");
        // R2/R6: program bus times temp into B, negative result
        setop(1, 2'b00, 1, 2'd2, 1, 2'd0, 1, 0, 0, 16'hFFFE, 16'h0, 16'h0300);
        step("R2");
        // R6: feedback A[32:16] (0x1000) times data 3, accumulate into B
        fb_sel = 1'b0;
        setop(1, 2'b01, 1, 2'd3, 1, 2'd1, 1, 0, 0, 16'h0, 16'h0003, 16'h0);
        step("R6");
        // R7: unsigned FFFF*FFFF into A
        setop(1, 2'b00, 0, 2'd1, 0, 2'd2, 0, 0, 0, 16'h0, 16'hFFFF, 16'hFFFF);
        step("R7");
        // R7: signed FFFF*FFFF = 1
        setop(1, 2'b00, 0, 2'd1, 1, 2'd2, 1, 0, 0, 16'h0, 16'hFFFF, 16'hFFFF);
        step("R7");
        // R3: guard growth by repeated unsigned accumulation
        setop(1, 2'b00, 0, 2'd1, 0, 2'd2, 0, 0, 0, 16'h0, 16'hFFFF, 16'hFFFF);
        step("R3");
        op = 2'b01;
        for (int i = 0; i < 6; i++) step("R3");
        if (acc_a[39:32] == 8'd0) begin
            fails++;
            $display("FAIL R3: got guard=%h expected nonzero", acc_a[39:32]);
        end
        checks++;
        // R3: subtract
        op = 2'b10;
        step("R3");
        // R4: en low and NOP
        en = 1'b0; op = 2'b01;
        step("R4");
        en = 1'b1; op = 2'b11;
        step("R4");
        // R11: sat off big result, no flag
        setop(1, 2'b00, 1, 2'd1, 0, 2'd2, 0, 1, 0, 16'h0, 16'hFFFF, 16'hFFFF);
        step("R11");
        // R8: fractional doubling
        setop(1, 2'b00, 0, 2'd0, 1, 2'd1, 1, 1, 0, 16'h1234, 16'hF00D, 16'h0);
        step("R8");
        // R9: positive clamp into B, flag raised
        setop(1, 2'b00, 1, 2'd1, 0, 2'd2, 0, 0, 1, 16'h0, 16'hFFFF, 16'hFFFF);
        step("R9");
        // R9: negative clamp into A (fractional -32768*65535*2)
        setop(1, 2'b00, 0, 2'd1, 1, 2'd2, 0, 1, 1, 16'h0, 16'h8000, 16'hFFFF);
        step("R9");
        // R10: flags stay set through NOP
        setop(1, 2'b11, 0, 2'd0, 1, 2'd0, 1, 0, 0, 16'h0, 16'h0, 16'h0);
        step("R10");
        // R10: clear A while no operation
        clr_ovf_a = 1'b1;
        step("R10");
        // R10: clear B with coincident clamp on B keeps flag
        setop(1, 2'b00, 1, 2'd1, 0, 2'd2, 0, 0, 1, 16'h0, 16'hFFFF, 16'hFFFF);
        clr_ovf_b = 1'b1;
        step("R10");
        clr_ovf_b = 1'b1; en = 1'b0;
        step("R10");
        clr_ovf_b = 1'b0;

        // Randomized mix
        for (int i = 0; i < 400; i++) begin
            en = ($urandom % 8) != 0;
            op = 2'($urandom);
            dst = 1'($urandom);
            x_sel = 2'($urandom); x_signed = 1'($urandom);
            y_sel = 2'($urandom); y_signed = 1'($urandom);
            fb_sel = 1'($urandom);
            frac = 1'($urandom);
            sat_en = 1'($urandom);
            t_val = 16'($urandom); dbus = 16'($urandom); pbus = 16'($urandom);
            clr_ovf_a = ($urandom % 6) == 0;
            clr_ovf_b = ($urandom % 6) == 0;
            if (!en || op == 2'b11) step("R4");
            else if (sat_en)        step("R9");
            else if (op == 2'b00)   step("R2");
            else                    step("R3");
        end

        // R1: asynchronous reset mid-run
        #1 rst_n = 1'b0;
        m_a = '0; m_b = '0; m_oa = 1'b0; m_ob = 1'b0;
        #2 check("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule